// File: doc/BRIEF.md
# Passive Four-Phase Receive Port

This block is the input side of the wrapper around a locally clocked module. It takes part in a four-phase bundled-data exchange without ever starting one. The local module asks for a word by raising its read line. The port then asserts a clock-hold request, which keeps the local clock's low phase stretched. It waits until the sender raises its request. It answers with an acknowledge and captures the bundled data word on that same edge. When the sender withdraws its request, the port drops the acknowledge and releases the clock hold together.

The port is modelled as synchronous logic on a fast reference clock. The read line and the downstream-accepted enable are synchronous to that clock. The sender's request arrives asynchronously and is brought in through a synchronizer chain whose depth is a parameter. The captured word is held in an output register. A one-cycle valid strobe marks each new word.

Top module: `rx_hs_port`

## Requirements
- R1: While rst_ni is low, ack_o, stretch_o and valid_o are 0 and data_o is all zeros.
- R2: A 0-to-1 change on rd_i makes stretch_o 1 at the next rising clock edge. stretch_o then stays 1, with ack_o 0, for as long as no synchronized request is seen.
- R3: ack_o is 1 only while stretch_o is 1. With a read pending and out_accepted_i high, ack_o rises at the third rising clock edge after req_i goes high. That count is two synchronizer stages plus the state register.
- R4: data_o takes the value of data_i at the clock edge where ack_o rises. valid_o is 1 for exactly that one cycle. data_o does not change at any other time.
- R5: ack_o falls at the third rising clock edge after req_i goes low. stretch_o falls at the same edge.
- R6: While out_accepted_i is 0, no acknowledge is given. When out_accepted_i goes to 1 while the synchronized request is already high, ack_o rises at the next clock edge.
- R7: A request on req_i with no read pending is never acknowledged, and stretch_o stays 0.
- R8: rd_i is edge-sensitive. A one-cycle pulse is enough to complete a reception. Holding rd_i high after a reception does not start another one.
- R9: A 0-to-1 change on rd_i while a reception is already in progress is ignored. After that reception completes, stretch_o stays 0 and no further word is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read demand from the local module, edge-sensitive |
| out_accepted_i | input | 1 | High once the module's previous output has been taken downstream |
| req_i | input | 1 | Asynchronous request from the sender |
| data_i | input | DATA_W | Bundled data word from the sender |
| ack_o | output | 1 | Acknowledge to the sender |
| stretch_o | output | 1 | Clock-hold request to the local clock generator |
| data_o | output | DATA_W | Captured data word |
| valid_o | output | 1 | One-cycle strobe for a newly captured word |

## Verification
The bench counts clock edges exactly from a request edge to the acknowledge edge in both directions. A design with a missing or extra synchronizer stage, or with the acknowledge released later than the clock hold, therefore fails on latency rather than on function. Several scenarios target the refusal rules:
- A sender that raises its request before any read is made. A port that starts a handshake on its own would acknowledge it.
- A read held at a constant high level, and a second read edge that arrives mid-handshake. Either one would trigger a spurious second reception in a level-sensitive or queueing design.
- out_accepted_i held low. A design that ignores it would capture a word too early.

Data values that differ between rounds show whether a capture happens at the wrong edge or more than once.

// File: rtl/rx_hs_pkg.sv
package rx_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_hs_sync.sv
module rx_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_hs_edge.sv
module rx_hs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/rx_hs_ctrl.sv
module rx_hs_ctrl
  import rx_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_rise_i,
  input  logic req_s_i,
  input  logic accept_i,
  output logic ack_o,
  output logic stretch_o,
  output logic cap_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rd_rise_i) state_d = ST_WAIT;
      ST_WAIT: if (req_s_i && accept_i) state_d = ST_ACK;
      ST_ACK:  if (!req_s_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ack_o     = (state_q == ST_ACK);
  assign stretch_o = (state_q != ST_IDLE);
  // strobe on the edge that enters ST_ACK
  assign cap_o     = (state_q == ST_WAIT) && req_s_i && accept_i;
endmodule

// File: rtl/rx_hs_dreg.sv
module rx_hs_dreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/rx_hs_port.sv
module rx_hs_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              out_accepted_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              stretch_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic req_sync;
  logic rd_rise;
  logic cap;

  rx_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(req_sync)
  );

  rx_hs_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(rd_i), .rise_o(rd_rise)
  );

  rx_hs_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_rise_i(rd_rise),
    .req_s_i(req_sync), .accept_i(out_accepted_i),
    .ack_o(ack_o), .stretch_o(stretch_o), .cap_o(cap)
  );

  rx_hs_dreg #(.DATA_W(DATA_W)) u_dreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .d_i(data_i),
    .q_o(data_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/rx_hs_port_chk.sv
module rx_hs_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_accepted_i,
  input logic              req_sync,
  input logic              ack_o,
  input logic              stretch_o,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o
);
  assert_ack_in_stretch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> stretch_o);

  assert_ack_rise_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(req_sync) && $past(out_accepted_i) && $past(stretch_o)));

  assert_valid_with_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ack_o && !$past(ack_o)));

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  assert_ack_fall_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (!$past(req_sync) && $fell(stretch_o)));
endmodule

bind rx_hs_port rx_hs_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_accepted_i(out_accepted_i),
  .req_sync(req_sync), .ack_o(ack_o), .stretch_o(stretch_o),
  .data_o(data_o), .valid_o(valid_o)
);

// File: tb/rx_hs_port_tb.sv
`timescale 1ns/1ps
module rx_hs_port_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_i = 1'b0;
  logic          acc_i = 1'b1;
  logic          req_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          ack_o, stretch_o, valid_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rx_hs_port #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .out_accepted_i(acc_i),
    .req_i(req_i), .data_i(data_i), .ack_o(ack_o), .stretch_o(stretch_o),
    .data_o(data_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse();
    rd_i = 1'b1;
    cyc(1);
    rd_i = 1'b0;
  endtask

  // full exchange from idle; checks R2..R5 timing
  task automatic exchange(input logic [DW-1:0] w);
    @(negedge clk);
    rd_pulse();
    chk(stretch_o === 1'b1, "R2 stretch after rd", stretch_o, 1);
    cyc(3);
    chk(stretch_o === 1'b1 && ack_o === 1'b0, "R2 hold while no req", {stretch_o, ack_o}, 2);
    data_i = w;
    req_i  = 1'b1;
    cyc(2);
    chk(ack_o === 1'b0, "R3 ack not early", ack_o, 0);
    cyc(1);
    chk(ack_o === 1'b1, "R3 ack third edge", ack_o, 1);
    chk(data_o === w, "R4 data captured", data_o, w);
    chk(valid_o === 1'b1, "R4 valid strobe", valid_o, 1);
    data_i = ~w;
    cyc(1);
    chk(valid_o === 1'b0, "R4 valid one cycle", valid_o, 0);
    chk(data_o === w, "R4 data held", data_o, w);
    req_i = 1'b0;
    cyc(2);
    chk(ack_o === 1'b1 && stretch_o === 1'b1, "R5 not early", {ack_o, stretch_o}, 3);
    cyc(1);
    chk(ack_o === 1'b0 && stretch_o === 1'b0, "R5 ack and stretch drop", {ack_o, stretch_o}, 0);
  endtask

  task automatic t_reset();
    chk(ack_o === 1'b0 && stretch_o === 1'b0 && valid_o === 1'b0 && data_o === '0,
        "R1 reset state", {ack_o, stretch_o, valid_o, data_o}, 0);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic t_patterns();
    exchange(8'hA5);
    exchange(8'h5A);
    exchange(8'hFF);
    exchange(8'h00);
  endtask

  task automatic t_no_read();
    int seen = 0;
    data_i = 8'h3C;
    req_i  = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      if (ack_o !== 1'b0 || stretch_o !== 1'b0) seen++;
    end
    chk(seen == 0, "R7 no self-start", seen, 0);
    rd_pulse();
    chk(stretch_o === 1'b1 && ack_o === 1'b0, "R2 stretch with req waiting", {stretch_o, ack_o}, 2);
    cyc(1);
    chk(ack_o === 1'b1 && data_o === 8'h3C, "R3 ack with req waiting", data_o, 8'h3C);
    req_i = 1'b0;
    cyc(4);
  endtask

  task automatic t_accept();
    acc_i = 1'b0;
    rd_pulse();
    data_i = 8'h77;
    req_i  = 1'b1;
    cyc(6);
    chk(ack_o === 1'b0 && valid_o === 1'b0 && stretch_o === 1'b1, "R6 blocked",
        {ack_o, valid_o, stretch_o}, 1);
    acc_i = 1'b1;
    cyc(1);
    chk(ack_o === 1'b1 && data_o === 8'h77, "R6 ack after accept", {ack_o, data_o}, 9'h177);
    req_i = 1'b0;
    cyc(4);
  endtask

  task automatic t_rd_level();
    int caps = 0;
    rd_i = 1'b1;
    cyc(1);
    data_i = 8'h21;
    req_i  = 1'b1;
    cyc(3);
    chk(ack_o === 1'b1, "R8 ack with rd held", ack_o, 1);
    req_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      if (valid_o) caps++;
    end
    chk(stretch_o === 1'b0, "R8 held rd no restart", stretch_o, 0);
    req_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      if (valid_o || ack_o) caps++;
    end
    chk(caps == 0, "R8 no second capture", caps, 0);
    rd_i  = 1'b0;
    req_i = 1'b0;
    cyc(4);
  endtask

  task automatic t_rd_busy();
    int caps = 0;
    rd_pulse();
    cyc(1);
    rd_pulse();
    data_i = 8'h4E;
    req_i  = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      if (valid_o) caps++;
    end
    chk(caps == 1 && data_o === 8'h4E, "R9 single capture", caps, 1);
    req_i = 1'b0;
    cyc(3);
    chk(stretch_o === 1'b0, "R9 released", stretch_o, 0);
    cyc(5);
    chk(stretch_o === 1'b0 && data_o === 8'h4E, "R9 busy rd ignored", stretch_o, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_patterns();
    t_no_read();
    t_accept();
    t_rd_level();
    t_rd_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule